// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches virtual-to-physical page translations in a small, fully associative array. Each slot holds a virtual page tag, a physical page number, an address-space number, a match-any-space flag, separate per-mode read and write enable masks, and two fault-on-access flags. A lookup compares the presented virtual page number and address-space number against every slot in the same cycle. It returns a hit flag, the index of the winning slot and that slot's fields.

New translations are written through an insert port. The slot is always the one named by a rotating next-slot pointer, and the insert evicts whatever that slot held. A separate index port shows the slot under the pointer and can advance the pointer without writing. A maintenance command port has three operations: drop every entry, drop only the entries tied to one address space, and drop the entries that match a given page and space. Page-table walking and permission enforcement are handled by the logic around the block.

Top module: `xlat_buffer`

## Requirements
- R1: A slot hits only when it is valid, its tag equals `lk_vpn`, and either its match-any-space flag is set or its address-space number equals `lk_asn`. `lk_hit` is 1 exactly when at least one slot hits.
- R2: When several slots hit, the lowest index wins. `lk_idx` and the field outputs carry that slot, and `lk_onehot` has only that slot's bit set. On a miss, `lk_onehot` is all zero.
- R3: With `ins_valid` high, the next clock edge writes all inserted fields into the slot at the pointer and marks it valid.
- R4: The pointer advances by exactly one at an edge where `ins_valid` or `ptr_adv` is high, even when both are high. It wraps from the last slot to 0 and otherwise holds.
- R5: `cmd_op` = 2'b01 (flush all) invalidates every slot and sets the pointer to 0 at the next edge. It overrides an insert or advance in the same cycle.
- R6: `cmd_op` = 2'b10 (flush space-private) invalidates every slot whose match-any-space flag is clear and leaves flagged slots valid.
- R7: `cmd_op` = 2'b11 (flush by address) invalidates exactly the slots that `cmd_vpn`/`cmd_asn` would hit under the R1 rule. `cmd_op` = 2'b00 does nothing.
- R8: When an R6 or R7 flush shares a cycle with an insert, the flush acts on the contents before the edge. The newly inserted slot stays valid.
- R9: Synchronous active-high reset leaves every slot invalid and the pointer at 0.
- R10: `ptr_idx`, `ptr_valid`, `ptr_vpn` and `ptr_ppn` show the slot under the pointer.
- R11: Lookup outputs follow the lookup inputs without a clock. An insert or flush becomes visible only after the edge.
- R12: The default depth is 48 slots, so the pointer returns to 0 after 48 advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Winning slot index |
| lk_onehot | output | N | One-hot winning slot |
| lk_ppn | output | PPN_W | Physical page of winner (0 on miss) |
| lk_any_space | output | 1 | Match-any-space flag of winner |
| lk_rd_en | output | MODE_W | Per-mode read enables of winner |
| lk_wr_en | output | MODE_W | Per-mode write enables of winner |
| lk_fault_rd | output | 1 | Fault-on-read flag of winner |
| lk_fault_wr | output | 1 | Fault-on-write flag of winner |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Inserted tag |
| ins_ppn | input | PPN_W | Inserted physical page |
| ins_asn | input | ASN_W | Inserted address-space number |
| ins_any_space | input | 1 | Inserted match-any-space flag |
| ins_rd_en | input | MODE_W | Inserted read enables |
| ins_wr_en | input | MODE_W | Inserted write enables |
| ins_fault_rd | input | 1 | Inserted fault-on-read flag |
| ins_fault_wr | input | 1 | Inserted fault-on-write flag |
| cmd_op | input | 2 | Maintenance command (00 none, 01 all, 10 private, 11 address) |
| cmd_vpn | input | VPN_W | Page for flush by address |
| cmd_asn | input | ASN_W | Space for flush by address |
| ptr_adv | input | 1 | Advance pointer without writing |
| ptr_idx | output | IDX_W | Current pointer |
| ptr_valid | output | 1 | Valid bit of slot under pointer |
| ptr_vpn | output | VPN_W | Tag of slot under pointer |
| ptr_ppn | output | PPN_W | Physical page of slot under pointer |

## Verification
A stale or wrongly cleared valid bit shows up at the lookup port in the first cycle that a matching page is presented. It appears as a miss where a hit is due, or as a hit from a slot that should be gone. A pointer that slips by one misplaces every later insert. That shows at `ptr_idx` in the next cycle and at `lk_idx` on the next lookup of the inserted page. The bench keeps a shadow copy of the table and compares lookup and pointer outputs every cycle. It uses a small page and space range, so duplicate tags, global entries and mixed flushes come up often.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VPN_W  = 20;
    localparam int PPN_W  = 24;
    localparam int ASN_W  = 8;
    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        OP_NONE       = 2'b00,
        OP_FLUSH_ALL  = 2'b01,
        OP_FLUSH_PRIV = 2'b10,
        OP_FLUSH_ADDR = 2'b11
    } maint_op_e;

    typedef struct packed {
        logic [VPN_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [ASN_W-1:0]  asn;
        logic              any_space;
        logic [MODE_W-1:0] rd_en;
        logic [MODE_W-1:0] wr_en;
        logic              fault_rd;
        logic              fault_wr;
    } xlat_entry_t;

    // Hit rule shared by lookup and flush-by-address.
    function automatic logic slot_hits(
        input logic              vld,
        input xlat_entry_t       ent,
        input logic [VPN_W-1:0]  vpn,
        input logic [ASN_W-1:0]  asn
    );
        return vld && (ent.tag == vpn) && (ent.any_space || (ent.asn == asn));
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N = 48
)(
    input  logic [N-1:0]            valid_q,
    input  xlat_entry_t [N-1:0]     ents_q,
    input  logic [VPN_W-1:0]        vpn,
    input  logic [ASN_W-1:0]        asn,
    output logic [N-1:0]            match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = slot_hits(valid_q[g], ents_q[g], vpn, asn);
    end
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
    parameter int N     = 48,
    parameter int IDX_W = $clog2(N)
)(
    input  logic [N-1:0]     match,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign hit    = |match;
    assign onehot = match & (~match + 1'b1);
endmodule

// File: rtl/xlat_victim_ptr.sv
module xlat_victim_ptr #(
    parameter int N     = 48,
    parameter int IDX_W = $clog2(N)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int N     = 48,
    parameter int IDX_W = $clog2(N)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                wipe,
    input  logic [N-1:0]        kill,
    input  logic                wr,
    input  logic [IDX_W-1:0]    wr_idx,
    input  xlat_entry_t         wr_ent,
    output logic [N-1:0]        valid_q,
    output xlat_entry_t [N-1:0] ents_q
);
    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_q & ~kill;
            if (wr) valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ents_q <= '0;
        end else if (wr && !wipe) begin
            ents_q[wr_idx] <= wr_ent;
        end
    end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int N = 48,
    localparam int IDX_W = $clog2(N)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [N-1:0]      lk_onehot,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_any_space,
    output logic [MODE_W-1:0] lk_rd_en,
    output logic [MODE_W-1:0] lk_wr_en,
    output logic              lk_fault_rd,
    output logic              lk_fault_wr,
    input  logic              ins_valid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic              ins_any_space,
    input  logic [MODE_W-1:0] ins_rd_en,
    input  logic [MODE_W-1:0] ins_wr_en,
    input  logic              ins_fault_rd,
    input  logic              ins_fault_wr,
    input  logic [1:0]        cmd_op,
    input  logic [VPN_W-1:0]  cmd_vpn,
    input  logic [ASN_W-1:0]  cmd_asn,
    input  logic              ptr_adv,
    output logic [IDX_W-1:0]  ptr_idx,
    output logic              ptr_valid,
    output logic [VPN_W-1:0]  ptr_vpn,
    output logic [PPN_W-1:0]  ptr_ppn
);
    maint_op_e            op;
    logic [N-1:0]         valid_q;
    xlat_entry_t [N-1:0]  ents_q;
    logic [N-1:0]         lk_match;
    logic [N-1:0]         cmd_match;
    logic [N-1:0]         private_vec;
    logic [N-1:0]         kill;
    logic                 wipe;
    logic                 wr;
    logic                 step;
    xlat_entry_t          new_ent;
    xlat_entry_t          win_ent;
    xlat_entry_t          ptr_ent;

    assign op = maint_op_e'(cmd_op);

    xlat_match #(.N(N)) u_lk_match (
        .valid_q (valid_q),
        .ents_q  (ents_q),
        .vpn     (lk_vpn),
        .asn     (lk_asn),
        .match   (lk_match)
    );

    xlat_match #(.N(N)) u_cmd_match (
        .valid_q (valid_q),
        .ents_q  (ents_q),
        .vpn     (cmd_vpn),
        .asn     (cmd_asn),
        .match   (cmd_match)
    );

    xlat_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .match  (lk_match),
        .hit    (lk_hit),
        .idx    (lk_idx),
        .onehot (lk_onehot)
    );

    for (genvar g = 0; g < N; g++) begin : g_priv
        assign private_vec[g] = valid_q[g] && !ents_q[g].any_space;
    end

    always_comb begin
        kill = '0;
        unique case (op)
            OP_FLUSH_PRIV: kill = private_vec;
            OP_FLUSH_ADDR: kill = cmd_match;
            default:       kill = '0;
        endcase
    end

    assign wipe = (op == OP_FLUSH_ALL);
    assign wr   = ins_valid && !wipe;
    assign step = (ins_valid || ptr_adv) && !wipe;

    always_comb begin
        new_ent.tag       = ins_vpn;
        new_ent.ppn       = ins_ppn;
        new_ent.asn       = ins_asn;
        new_ent.any_space = ins_any_space;
        new_ent.rd_en     = ins_rd_en;
        new_ent.wr_en     = ins_wr_en;
        new_ent.fault_rd  = ins_fault_rd;
        new_ent.fault_wr  = ins_fault_wr;
    end

    xlat_victim_ptr #(.N(N), .IDX_W(IDX_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .clear (wipe),
        .step  (step),
        .ptr   (ptr_idx)
    );

    xlat_store #(.N(N), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wipe    (wipe),
        .kill    (kill),
        .wr      (wr),
        .wr_idx  (ptr_idx),
        .wr_ent  (new_ent),
        .valid_q (valid_q),
        .ents_q  (ents_q)
    );

    assign win_ent = lk_hit ? ents_q[lk_idx] : '0;
    assign ptr_ent = ents_q[ptr_idx];

    assign lk_ppn       = win_ent.ppn;
    assign lk_any_space = win_ent.any_space;
    assign lk_rd_en     = win_ent.rd_en;
    assign lk_wr_en     = win_ent.wr_en;
    assign lk_fault_rd  = win_ent.fault_rd;
    assign lk_fault_wr  = win_ent.fault_wr;

    assign ptr_valid = valid_q[ptr_idx];
    assign ptr_vpn   = ptr_ent.tag;
    assign ptr_ppn   = ptr_ent.ppn;
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk
    import xlat_pkg::*;
#(
    parameter int N     = 48,
    parameter int IDX_W = $clog2(N)
)(
    input logic                clk,
    input logic                rst,
    input logic                lk_hit,
    input logic [IDX_W-1:0]    lk_idx,
    input logic [N-1:0]        lk_onehot,
    input logic                ins_valid,
    input logic                ptr_adv,
    input logic [1:0]          cmd_op,
    input logic [IDX_W-1:0]    ptr_idx,
    input logic [N-1:0]        valid_q,
    input xlat_entry_t [N-1:0] ents_q
);
    logic [IDX_W-1:0] ptr_next;
    logic [N-1:0]     priv_live;
    logic             moves;
    logic             wiping;

    assign ptr_next = (ptr_idx == IDX_W'(N - 1)) ? '0 : ptr_idx + 1'b1;
    assign wiping   = (cmd_op == 2'b01);
    assign moves    = (ins_valid || ptr_adv) && !wiping;

    for (genvar g = 0; g < N; g++) begin : g_pl
        assign priv_live[g] = valid_q[g] && !ents_q[g].any_space;
    end

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_onehot) && (lk_hit == (lk_onehot != '0)));

    assert_winner_R2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_onehot[lk_idx]);

    assert_insert_R3: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !wiping) |=> valid_q[$past(ptr_idx)]);

    assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
        moves |=> (ptr_idx == $past(ptr_next)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!moves && !wiping) |=> $stable(ptr_idx));

    assert_flush_all_R5: assert property (@(posedge clk) disable iff (rst)
        wiping |=> (valid_q == '0) && (ptr_idx == '0));

    assert_flush_priv_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'b10 && !ins_valid) |=> (priv_live == '0));
endmodule

bind xlat_buffer xlat_buffer_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .lk_onehot (lk_onehot),
    .ins_valid (ins_valid),
    .ptr_adv   (ptr_adv),
    .cmd_op    (cmd_op),
    .ptr_idx   (ptr_idx),
    .valid_q   (valid_q),
    .ents_q    (ents_q)
);

// File: tb/tb_xlat_buffer.sv
module tb_xlat_buffer;
    import xlat_pkg::*;

    localparam int N      = 48;
    localparam int IDX_W  = $clog2(N);
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [ASN_W-1:0]  lk_asn = '0;
    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [N-1:0]      lk_onehot;
    logic [PPN_W-1:0]  lk_ppn;
    logic              lk_any_space;
    logic [MODE_W-1:0] lk_rd_en, lk_wr_en;
    logic              lk_fault_rd, lk_fault_wr;
    logic              ins_valid = 0;
    logic [VPN_W-1:0]  ins_vpn = '0;
    logic [PPN_W-1:0]  ins_ppn = '0;
    logic [ASN_W-1:0]  ins_asn = '0;
    logic              ins_any_space = 0;
    logic [MODE_W-1:0] ins_rd_en = '0, ins_wr_en = '0;
    logic              ins_fault_rd = 0, ins_fault_wr = 0;
    logic [1:0]        cmd_op = 2'b00;
    logic [VPN_W-1:0]  cmd_vpn = '0;
    logic [ASN_W-1:0]  cmd_asn = '0;
    logic              ptr_adv = 0;
    logic [IDX_W-1:0]  ptr_idx;
    logic              ptr_valid;
    logic [VPN_W-1:0]  ptr_vpn;
    logic [PPN_W-1:0]  ptr_ppn;

    xlat_buffer #(.N(N)) dut (.*);

    // shadow table
    bit                m_valid [N];
    logic [VPN_W-1:0]  m_tag   [N];
    logic [PPN_W-1:0]  m_ppn   [N];
    logic [ASN_W-1:0]  m_asn   [N];
    bit                m_glb   [N];
    logic [MODE_W-1:0] m_rd    [N];
    logic [MODE_W-1:0] m_wr    [N];
    bit                m_frd   [N];
    bit                m_fwr   [N];
    int                m_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit ref_hit(input int i, input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a);
        return m_valid[i] && m_tag[i] == v && (m_glb[i] || m_asn[i] == a);
    endfunction

    function automatic int ref_find(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a);
        for (int i = 0; i < N; i++) if (ref_hit(i, v, a)) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        m_ptr = 0;
    endtask

    task automatic model_edge();
        bit kill [N];
        for (int i = 0; i < N; i++) begin
            kill[i] = 0;
            if (cmd_op == 2'b10) kill[i] = m_valid[i] && !m_glb[i];
            if (cmd_op == 2'b11) kill[i] = ref_hit(i, cmd_vpn, cmd_asn);
        end
        if (cmd_op == 2'b01) begin
            model_reset();
        end else begin
            for (int i = 0; i < N; i++) if (kill[i]) m_valid[i] = 0;
            if (ins_valid) begin
                m_valid[m_ptr] = 1; m_tag[m_ptr] = ins_vpn; m_ppn[m_ptr] = ins_ppn;
                m_asn[m_ptr] = ins_asn; m_glb[m_ptr] = ins_any_space;
                m_rd[m_ptr] = ins_rd_en; m_wr[m_ptr] = ins_wr_en;
                m_frd[m_ptr] = ins_fault_rd; m_fwr[m_ptr] = ins_fault_wr;
            end
            if (ins_valid || ptr_adv) m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
        end
    endtask

    task automatic check_outputs();
        int e;
        logic [N-1:0] eoh;
        e = ref_find(lk_vpn, lk_asn);
        chk(lk_hit == (e >= 0), "R1 hit", 64'(lk_hit), 64'(e >= 0));
        eoh = '0;
        if (e >= 0) begin
            eoh[e] = 1'b1;
            chk(lk_idx == IDX_W'(e), "R2 index", 64'(lk_idx), 64'(e));
            chk({lk_ppn, lk_any_space, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr} ==
                {m_ppn[e], m_glb[e], m_rd[e], m_wr[e], m_frd[e], m_fwr[e]}, "R2 fields",
                64'({lk_ppn, lk_any_space, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr}),
                64'({m_ppn[e], m_glb[e], m_rd[e], m_wr[e], m_frd[e], m_fwr[e]}));
        end
        chk(lk_onehot == eoh, "R2 onehot", 64'(lk_onehot), 64'(eoh));
        chk(ptr_idx == IDX_W'(m_ptr), "R10 ptr_idx", 64'(ptr_idx), 64'(m_ptr));
        chk(ptr_valid == m_valid[m_ptr], "R10 ptr_valid", 64'(ptr_valid), 64'(m_valid[m_ptr]));
        if (m_valid[m_ptr])
            chk(ptr_vpn == m_tag[m_ptr] && ptr_ppn == m_ppn[m_ptr], "R10 ptr fields",
                64'({ptr_vpn, ptr_ppn}), 64'({m_tag[m_ptr], m_ppn[m_ptr]}));
    endtask

    // inputs are set by caller after a negedge; one full cycle
    task automatic cycle();
        #1 check_outputs();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        ins_valid = 0; cmd_op = 2'b00; ptr_adv = 0;
    endtask

    task automatic set_ins(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                           input logic [ASN_W-1:0] a, input bit g);
        ins_valid = 1; ins_vpn = v; ins_ppn = p; ins_asn = a; ins_any_space = g;
        ins_rd_en = MODE_W'(p); ins_wr_en = MODE_W'(p >> 4);
        ins_fault_rd = p[1]; ins_fault_wr = p[2];
    endtask

    task automatic probe(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a,
                         input string req, input int exp_idx);
        lk_vpn = v; lk_asn = a;
        #1;
        chk(lk_hit == (exp_idx >= 0) && (exp_idx < 0 || lk_idx == IDX_W'(exp_idx)),
            req, 64'({lk_hit, lk_idx}), 64'(exp_idx));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R9: after reset everything invalid, pointer 0
        chk(ptr_idx == '0 && !ptr_valid, "R9 reset state", 64'({ptr_idx, ptr_valid}), 64'(0));
        probe(20'd0, 8'd0, "R9 miss after reset", -1);

        // R3/R11: slot 0 private vpn5 asn1; invisible before the edge
        set_ins(20'd5, 24'h111, 8'd1, 0);
        lk_vpn = 20'd5; lk_asn = 8'd1;
        #1 chk(!lk_hit, "R11 insert not visible before edge", 64'(lk_hit), 64'(0));
        cycle();
        probe(20'd5, 8'd1, "R3 inserted slot 0 hits", 0);
        chk(lk_ppn == 24'h111, "R3 ppn stored", 64'(lk_ppn), 64'h111);
        // slot 1 global vpn5 asn2
        set_ins(20'd5, 24'h222, 8'd2, 1); cycle();
        probe(20'd5, 8'd1, "R2 lowest index wins", 0);
        probe(20'd5, 8'd3, "R1 global matches any space", 1);
        probe(20'd5, 8'd2, "R1 private slot other space misses, global hits", 1);
        probe(20'd6, 8'd1, "R1 tag mismatch misses", -1);

        // R6: private flush drops slot 0, keeps slot 1
        cmd_op = 2'b10; cycle();
        probe(20'd5, 8'd1, "R6 global slot survives", 1);
        // R7: flush by address, any space hits the global slot
        set_ins(20'd7, 24'h333, 8'd4, 0); cycle();
        cmd_op = 2'b11; cmd_vpn = 20'd5; cmd_asn = 8'd9; cycle();
        probe(20'd5, 8'd9, "R7 flush by address removed global", -1);
        probe(20'd7, 8'd4, "R7 non-matching slot kept", 2);
        cmd_op = 2'b11; cmd_vpn = 20'd7; cmd_asn = 8'd5; cycle();
        probe(20'd7, 8'd4, "R7 space mismatch keeps private slot", 2);
        cmd_op = 2'b00; cmd_vpn = 20'd7; cmd_asn = 8'd4; cycle();
        probe(20'd7, 8'd4, "R7 no-op command keeps slot", 2);

        // R8: private flush and private insert together
        cmd_op = 2'b10; set_ins(20'd9, 24'h444, 8'd4, 0); cycle();
        probe(20'd7, 8'd4, "R8 old private slot flushed", -1);
        probe(20'd9, 8'd4, "R8 new insert survives", 3);

        // R4: advance only, and both together advance once
        ptr_adv = 1; cycle();
        chk(ptr_idx == 5, "R4 advance without write", 64'(ptr_idx), 64'(5));
        ptr_adv = 1; set_ins(20'd10, 24'h555, 8'd0, 0); cycle();
        chk(ptr_idx == 6, "R4 insert plus advance steps once", 64'(ptr_idx), 64'(6));
        probe(20'd10, 8'd0, "R3 insert at pointer 5", 5);

        // R12/R4: wrap after 48 steps
        for (int k = 0; k < N - 6; k++) begin ptr_adv = 1; cycle(); end
        chk(ptr_idx == '0, "R12 pointer wraps to 0 after 48 slots", 64'(ptr_idx), 64'(0));
        set_ins(20'd11, 24'h666, 8'd0, 0); cycle();
        probe(20'd11, 8'd0, "R4 wrapped insert goes to slot 0", 0);

        // R5: flush-all overrides an insert
        cmd_op = 2'b01; set_ins(20'd12, 24'h777, 8'd0, 1); ptr_adv = 1; cycle();
        chk(ptr_idx == '0 && !ptr_valid, "R5 flush-all pointer 0", 64'({ptr_idx, ptr_valid}), 64'(0));
        probe(20'd12, 8'd0, "R5 insert dropped by flush-all", -1);
        probe(20'd10, 8'd0, "R5 older slots gone", -1);

        // random mix
        for (int k = 0; k < 4000; k++) begin
            int r;
            lk_vpn = 20'($urandom % 8); lk_asn = 8'($urandom % 4);
            if (($urandom % 100) < 45)
                set_ins(20'($urandom % 8), 24'($urandom), 8'($urandom % 4), ($urandom % 4) == 0);
            ptr_adv = ($urandom % 10) == 0;
            r = $urandom % 100;
            cmd_vpn = 20'($urandom % 8); cmd_asn = 8'($urandom % 4);
            cmd_op = (r < 1) ? 2'b01 : (r < 5) ? 2'b10 : (r < 12) ? 2'b11 : 2'b00;
            cycle();
        end

        // reset mid-run: R9
        set_ins(20'd1, 24'h1, 8'd0, 1); cycle();
        rst = 1; @(posedge clk); model_reset(); @(negedge clk); rst = 0;
        probe(20'd1, 8'd0, "R9 reset clears slots", -1);
        chk(ptr_idx == '0, "R9 reset clears pointer", 64'(ptr_idx), 64'(0));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule